// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block steps a DDR2 memory interface from power-on to normal operation. It holds the PHY, the PHY's user logic and the PHY's DLL in reset. It releases them one at a time, each release followed by a minimum wait. It then observes the memory's power-up interval with CKE held low, raises CKE and selects the device. After that it hands control to an SDRAM mode-setup engine and then to a drive-calibration and termination-setup engine. Only when both engines report completion does it enable on-die termination control and raise its ready flag.

Every wait is a cycle count set by a parameter. The defaults suit a 166 MHz interface clock: 20 cycles for each 120 ns gap, 13167 cycles for the 79 µs DLL lock time and 33334 cycles for the 200 µs power-up interval. The block carries no data stream, so it has no valid/ready interface and no back-pressure. All pins are plain level controls. The only exceptions are the two one-cycle start pulses and the done levels that answer them.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: While `rst_ni` is low, `phy_rst_no`, `phy_urst_no` and `dll_rst_no` are 0, `cke_o`, `odt_en_o`, `init_start_o`, `cal_start_o` and `ready_o` are 0, and `cs_no` is 1.
- R2: After reset, the PHY resets stay asserted (0) until `pll_locked_i` and `phy_cfg_done_i` have both been seen high.
- R3: `phy_rst_no` and `phy_urst_no` rise to 1 together, CFG_WAIT_CYC+1 cycles after the cycle in which `phy_cfg_done_i` is first seen high while the PLL is locked, and they are equal on every cycle.
- R4: `dll_rst_no` rises to 1 exactly RST_WAIT_CYC cycles after `phy_rst_no` rises.
- R5: `cke_o` rises exactly DLL_WAIT_CYC+PWR_WAIT_CYC cycles after `dll_rst_no` rises. In that same cycle `cs_no` falls to 0 and `init_start_o` is high for exactly one cycle.
- R6: The sequencer waits for `init_done_i`. `cal_start_o` is a one-cycle pulse in the cycle after `init_done_i` is first seen high, and it is never raised before that.
- R7: `odt_en_o` and `ready_o` rise together in the cycle after `cal_done_i` is first seen high. `odt_en_o` is never 1 while `cke_o` is 0.
- R8: If `pll_locked_i` is low while `ready_o` is 0, the next cycle shows the R1 output values. The sequence then restarts from the PLL wait, and `phy_rst_no` rises CFG_WAIT_CYC+2 cycles after the lock returns, provided `phy_cfg_done_i` is held high.
- R9: Once `ready_o` is 1 it stays 1, including through loss of PLL lock, until `rst_ni` is asserted.
- R10: Release order holds on every cycle: `dll_rst_no` high implies both PHY resets are high, and `cke_o` high implies `dll_rst_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Chip reset, active low, asynchronous |
| pll_locked_i | input | 1 | PLL lock indication |
| phy_cfg_done_i | input | 1 | PHY register configuration finished (level) |
| init_done_i | input | 1 | SDRAM mode-setup engine finished (level) |
| cal_done_i | input | 1 | Drive calibration and termination setup finished (level) |
| phy_rst_no | output | 1 | PHY reset, active low |
| phy_urst_no | output | 1 | PHY user-logic reset, active low |
| dll_rst_no | output | 1 | PHY DLL reset, active low |
| cke_o | output | 1 | Memory clock enable |
| cs_no | output | 1 | Memory chip select, active low |
| odt_en_o | output | 1 | On-die termination control enable |
| init_start_o | output | 1 | One-cycle start pulse for the mode-setup engine |
| cal_start_o | output | 1 | One-cycle start pulse for the calibration engine |
| ready_o | output | 1 | Normal operation reached |

## Verification
The embedded properties check on every cycle:
- the release order of the resets, CKE and ODT;
- that the two PHY resets are equal;
- that the start strobes last one cycle;
- that the ready flag is sticky;
- that a lock loss forces a restart;
- that the wait counters step by one and hold at their terminal value.

The exact lengths of each wait, and the response to done flags arriving after various delays, are shown only by the bench's scenarios. The bench measures the distance between output edges and compares it with sums of the wait parameters. The same applies to the restart timing after a lock loss and to the ready flag surviving a lock loss once it is set.

// File: rtl/ddr2_pwrup_pkg.sv
package ddr2_pwrup_pkg;

  typedef enum logic [3:0] {
    ST_PLL,
    ST_CFG,
    ST_CFG_WAIT,
    ST_RST_WAIT,
    ST_DLL_WAIT,
    ST_PWR_WAIT,
    ST_INIT_GO,
    ST_INIT_WAIT,
    ST_CAL_GO,
    ST_CAL_WAIT,
    ST_READY
  } seq_state_e;

  typedef struct packed {
    logic phy_rst_n;
    logic phy_urst_n;
    logic dll_rst_n;
    logic cke;
    logic cs_n;
    logic odt_en;
    logic init_start;
    logic cal_start;
    logic ready;
  } pin_bundle_t;

endpackage

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] len_m1_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q == len_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (!expired_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the counter advances by one per cycle while the wait is running
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !expired_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R5: the counter holds its terminal value until the state moves on
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && expired_o) |=> (cnt_q == $past(cnt_q)));

  // R4: a clear always restarts the count from zero
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
  import ddr2_pwrup_pkg::*;
#(
  parameter int CFG_WAIT_CYC = 20,
  parameter int RST_WAIT_CYC = 20,
  parameter int DLL_WAIT_CYC = 13167,
  parameter int PWR_WAIT_CYC = 33334
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pll_locked_i,
  input  logic       phy_cfg_done_i,
  input  logic       init_done_i,
  input  logic       cal_done_i,
  output seq_state_e state_o
);

  localparam int MAX_A  = (CFG_WAIT_CYC > RST_WAIT_CYC) ? CFG_WAIT_CYC : RST_WAIT_CYC;
  localparam int MAX_B  = (DLL_WAIT_CYC > PWR_WAIT_CYC) ? DLL_WAIT_CYC : PWR_WAIT_CYC;
  localparam int MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = (MAX_W < 2) ? 1 : $clog2(MAX_W);

  seq_state_e       st_q, st_d;
  logic             tmr_clr, tmr_exp;
  logic [CNT_W-1:0] len_m1;

  always_comb begin
    unique case (st_q)
      ST_CFG_WAIT: len_m1 = CNT_W'(CFG_WAIT_CYC - 1);
      ST_RST_WAIT: len_m1 = CNT_W'(RST_WAIT_CYC - 1);
      ST_DLL_WAIT: len_m1 = CNT_W'(DLL_WAIT_CYC - 1);
      ST_PWR_WAIT: len_m1 = CNT_W'(PWR_WAIT_CYC - 1);
      default:     len_m1 = '0;
    endcase
  end

  always_comb begin
    st_d = st_q;
    if (st_q != ST_READY && st_q != ST_PLL && !pll_locked_i) begin
      st_d = ST_PLL;
    end else begin
      unique case (st_q)
        ST_PLL:       if (pll_locked_i)   st_d = ST_CFG;
        ST_CFG:       if (phy_cfg_done_i) st_d = ST_CFG_WAIT;
        ST_CFG_WAIT:  if (tmr_exp)        st_d = ST_RST_WAIT;
        ST_RST_WAIT:  if (tmr_exp)        st_d = ST_DLL_WAIT;
        ST_DLL_WAIT:  if (tmr_exp)        st_d = ST_PWR_WAIT;
        ST_PWR_WAIT:  if (tmr_exp)        st_d = ST_INIT_GO;
        ST_INIT_GO:                       st_d = ST_INIT_WAIT;
        ST_INIT_WAIT: if (init_done_i)    st_d = ST_CAL_GO;
        ST_CAL_GO:                        st_d = ST_CAL_WAIT;
        ST_CAL_WAIT:  if (cal_done_i)     st_d = ST_READY;
        default:                          st_d = ST_READY;
      endcase
    end
  end

  assign tmr_clr = (st_d != st_q);

  pwrup_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .len_m1_i  (len_m1),
    .expired_o (tmr_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_PLL;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  // R8: a lock loss before ready sends the machine back to the PLL wait
  p_lock_loss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pll_locked_i && st_q != ST_READY) |=> (st_q == ST_PLL));

  // R9: the ready state is never left without a chip reset
  p_ready_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_READY) |=> (st_q == ST_READY));

  // R6: the handshake states last exactly one cycle
  p_go_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CAL_GO || st_q == ST_INIT_GO) |=> (st_q != $past(st_q)));

endmodule

// File: rtl/pwrup_decode.sv
module pwrup_decode
  import ddr2_pwrup_pkg::*;
(
  input  seq_state_e  state_i,
  output pin_bundle_t pins_o
);

  logic phy_up, dll_up, mem_on;

  always_comb begin
    phy_up = state_i inside {ST_RST_WAIT, ST_DLL_WAIT, ST_PWR_WAIT, ST_INIT_GO,
                             ST_INIT_WAIT, ST_CAL_GO, ST_CAL_WAIT, ST_READY};
    dll_up = state_i inside {ST_DLL_WAIT, ST_PWR_WAIT, ST_INIT_GO,
                             ST_INIT_WAIT, ST_CAL_GO, ST_CAL_WAIT, ST_READY};
    mem_on = state_i inside {ST_INIT_GO, ST_INIT_WAIT, ST_CAL_GO,
                             ST_CAL_WAIT, ST_READY};

    pins_o.phy_rst_n  = phy_up;
    pins_o.phy_urst_n = phy_up;
    pins_o.dll_rst_n  = dll_up;
    pins_o.cke        = mem_on;
    pins_o.cs_n       = !mem_on;
    pins_o.odt_en     = (state_i == ST_READY);
    pins_o.init_start = (state_i == ST_INIT_GO);
    pins_o.cal_start  = (state_i == ST_CAL_GO);
    pins_o.ready      = (state_i == ST_READY);
  end

endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
  import ddr2_pwrup_pkg::*;
#(
  parameter int CFG_WAIT_CYC = 20,
  parameter int RST_WAIT_CYC = 20,
  parameter int DLL_WAIT_CYC = 13167,
  parameter int PWR_WAIT_CYC = 33334
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_locked_i,
  input  logic phy_cfg_done_i,
  input  logic init_done_i,
  input  logic cal_done_i,
  output logic phy_rst_no,
  output logic phy_urst_no,
  output logic dll_rst_no,
  output logic cke_o,
  output logic cs_no,
  output logic odt_en_o,
  output logic init_start_o,
  output logic cal_start_o,
  output logic ready_o
);

  seq_state_e  state;
  pin_bundle_t pins;

  pwrup_fsm #(
    .CFG_WAIT_CYC (CFG_WAIT_CYC),
    .RST_WAIT_CYC (RST_WAIT_CYC),
    .DLL_WAIT_CYC (DLL_WAIT_CYC),
    .PWR_WAIT_CYC (PWR_WAIT_CYC)
  ) fsm_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pll_locked_i   (pll_locked_i),
    .phy_cfg_done_i (phy_cfg_done_i),
    .init_done_i    (init_done_i),
    .cal_done_i     (cal_done_i),
    .state_o        (state)
  );

  pwrup_decode decode_i (
    .state_i (state),
    .pins_o  (pins)
  );

  assign phy_rst_no   = pins.phy_rst_n;
  assign phy_urst_no  = pins.phy_urst_n;
  assign dll_rst_no   = pins.dll_rst_n;
  assign cke_o        = pins.cke;
  assign cs_no        = pins.cs_n;
  assign odt_en_o     = pins.odt_en;
  assign init_start_o = pins.init_start;
  assign cal_start_o  = pins.cal_start;
  assign ready_o      = pins.ready;

  p_dll_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_rst_no |-> (phy_rst_no && phy_urst_no));

  p_cke_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |-> dll_rst_no);

  p_odt_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odt_en_o |-> (cke_o && ready_o));

  p_resets_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rst_no == phy_urst_no);

  p_init_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_start_o |=> !init_start_o);

  p_cke_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (init_start_o && !cs_no));

  p_cal_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |=> !cal_start_o);

  p_cal_after_init_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_start_o) |-> $past(init_done_i));

  p_ready_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  p_lock_loss_pins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pll_locked_i && !ready_o) |=> (!phy_rst_no && !dll_rst_no && !cke_o && cs_no));

endmodule

// File: tb/ddr2_pwrup_seq_tb_top.sv
module ddr2_pwrup_seq_tb_top;

  localparam int T_CFG = 5;
  localparam int T_RST = 6;
  localparam int T_DLL = 40;
  localparam int T_PWR = 50;
  localparam int GUARD = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pll = 1'b0, cfg_done = 1'b0, init_done = 1'b0, cal_done = 1'b0;
  logic phy_rst_n, phy_urst_n, dll_rst_n, cke, cs_n, odt_en, init_start, cal_start, ready;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_pwrup_seq #(
    .CFG_WAIT_CYC (T_CFG),
    .RST_WAIT_CYC (T_RST),
    .DLL_WAIT_CYC (T_DLL),
    .PWR_WAIT_CYC (T_PWR)
  ) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .pll_locked_i   (pll),
    .phy_cfg_done_i (cfg_done),
    .init_done_i    (init_done),
    .cal_done_i     (cal_done),
    .phy_rst_no     (phy_rst_n),
    .phy_urst_no    (phy_urst_n),
    .dll_rst_no     (dll_rst_n),
    .cke_o          (cke),
    .cs_no          (cs_n),
    .odt_en_o       (odt_en),
    .init_start_o   (init_start),
    .cal_start_o    (cal_start),
    .ready_o        (ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int pins_word();
    return {phy_rst_n, phy_urst_n, dll_rst_n, cke, cs_n, odt_en, init_start, cal_start, ready};
  endfunction

  // R1 idle pattern: only cs_n high -> 9'b000010000
  task automatic chip_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_done = 1'b0; init_done = 1'b0; cal_done = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(pins_word() == 9'h010, "R1 outputs in reset", pins_word(), 9'h010);
    end
    rst_n = 1'b1;
    pll = 1'b1;
  endtask

  task automatic full_run(input int dinit, input int dcal);
    int t0, t1, t2, t3, t4, g;
    repeat (3) @(negedge clk);
    chk(!phy_rst_n && !phy_urst_n, "R2 held without cfg done", phy_rst_n, 0);
    cfg_done = 1'b1; t0 = cyc;
    g = 0; do begin @(negedge clk); g++; end while (!phy_rst_n && g < GUARD);
    t1 = cyc;
    chk(t1 - t0 == T_CFG + 1, "R3 phy reset release time", t1 - t0, T_CFG + 1);
    chk(phy_urst_n == 1'b1, "R3 user reset released together", phy_urst_n, 1);
    chk(!dll_rst_n, "R10 dll after phy", dll_rst_n, 0);
    g = 0; do begin @(negedge clk); g++; end while (!dll_rst_n && g < GUARD);
    t2 = cyc;
    chk(t2 - t1 == T_RST, "R4 dll release time", t2 - t1, T_RST);
    g = 0; do begin @(negedge clk); g++; end while (!cke && g < GUARD);
    t3 = cyc;
    chk(t3 - t2 == T_DLL + T_PWR, "R5 cke rise time", t3 - t2, T_DLL + T_PWR);
    chk(init_start && !cs_n, "R5 start pulse and cs with cke", {init_start, cs_n}, 2);
    @(negedge clk);
    chk(!init_start, "R5 start pulse one cycle", init_start, 0);
    repeat (dinit - 1) begin
      @(negedge clk);
      chk(!cal_start, "R6 no cal start before init done", cal_start, 0);
    end
    init_done = 1'b1; t4 = cyc;
    @(negedge clk);
    chk(cal_start && cyc == t4 + 1, "R6 cal start after init done", cal_start, 1);
    init_done = 1'b0;
    @(negedge clk);
    chk(!cal_start, "R6 cal start one cycle", cal_start, 0);
    repeat (dcal - 1) begin
      @(negedge clk);
      chk(!ready && !odt_en, "R7 odt held before cal done", {odt_en, ready}, 0);
    end
    cal_done = 1'b1;
    @(negedge clk);
    chk(ready && odt_en && cke, "R7 odt and ready after cal done", {odt_en, ready}, 3);
    cal_done = 1'b0;
  endtask

  initial begin
    int p0, g;
    chip_reset();
    pll = 1'b0; cfg_done = 1'b1;
    repeat (6) @(negedge clk);
    chk(!phy_rst_n, "R2 held without pll lock", phy_rst_n, 0);
    cfg_done = 1'b0; pll = 1'b1;

    for (int di = 1; di <= 3; di++) begin
      for (int dc = 1; dc <= 3; dc++) begin
        full_run(di, dc);
        pll = 1'b0;
        repeat (3) begin
          @(negedge clk);
          chk(ready && odt_en, "R9 ready survives lock loss", ready, 1);
        end
        pll = 1'b1;
        chip_reset();
        chk(!ready, "R9 ready cleared by reset", ready, 0);
      end
    end

    // R8: lock loss in the middle of the DLL wait
    cfg_done = 1'b1;
    g = 0; do begin @(negedge clk); g++; end while (!dll_rst_n && g < GUARD);
    repeat (5) @(negedge clk);
    pll = 1'b0;
    @(negedge clk);
    chk(pins_word() == 9'h010, "R8 outputs after lock loss", pins_word(), 9'h010);
    repeat (4) @(negedge clk);
    chk(pins_word() == 9'h010, "R8 held while unlocked", pins_word(), 9'h010);
    pll = 1'b1; p0 = cyc;
    g = 0; do begin @(negedge clk); g++; end while (!phy_rst_n && g < GUARD);
    chk(cyc - p0 == T_CFG + 2, "R8 restart timing", cyc - p0, T_CFG + 2);
    init_done = 1'b1; cal_done = 1'b1;
    g = 0; do begin @(negedge clk); g++; end while (!ready && g < GUARD);
    chk(ready && odt_en, "R8 sequence completes after restart", ready, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule